// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Engine

The engine is handed a byte address and a start pulse. It reads a transfer descriptor from that address one halfword at a time. The first halfword holds the mode flags, and those flags decide which further 32-bit fields the descriptor contains. The engine then carries out the transfer the descriptor describes, using the same memory port.

Four kinds of transfer are supported:
- a plain block copy;
- a fill with an immediate value;
- a calculation that adds a source unit to an operand unit and stores the sum;
- a scatter/gather list of up to seven source/destination pairs.

After the units are moved, a descriptor may raise a completion strobe carrying a 32-bit vector taken from the descriptor. It may also name the base of a follow-on descriptor, which the engine fetches and runs without dropping busy.

The memory side is a single request/ready port with byte addresses and halfword data. It has one access outstanding at a time. The port carries a size bit that selects byte or halfword.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset `busy_o`, `mem_req_o` and `done_o` are low. `busy_o` goes high the cycle after `start_i` is sampled while idle. A `start_i` pulse while busy changes neither the descriptor that is run nor the memory traffic.
- R2: Mode halfword bits:
  - bit0: immediate source;
  - bit1: calculation;
  - bit2: follow-on descriptor;
  - bit3: completion vector;
  - bit4: pair-list mode;
  - bits 7:5: pair count;
  - bit8: unit size (0 byte, 1 halfword).

  Outside pair-list mode, the descriptor is read as halfwords from base upward in this order: mode, count, source (low half first), operand when bit1 is set, destination, follow-on base when bit2 is set, vector when bit3 is set. That is 12, 16, 20 or 24 bytes.
- R3: A block copy moves `count` units. The source and destination addresses advance by the unit size (1 or 2) after each unit.
- R4: With bit0 set, no source reads are issued. Every destination unit receives the low 16 bits of the source field (low 8 bits for byte units), and the upper 16 bits of that field are ignored.
- R5: With bit1 set, each destination unit receives the source unit (or immediate) plus the operand unit, modulo 2^8 or 2^16. The operand address advances with the others.
- R6: A count of zero performs no data reads or writes. Completion (vector and follow-on) still takes place.
- R7: In pair-list mode the descriptor is mode, count, then n pairs of (source, destination), for 4 + 8n bytes with n from bits 7:5. Each pair moves one unit. The count and bits 3:0 are ignored, and n = 0 moves nothing.
- R8: With bit2 set, after its units the engine fetches the descriptor at the follow-on base. `busy_o` stays high across the hand-over.
- R9: With bit3 set, `done_o` pulses for one cycle with `done_vec_o` equal to the vector field, once per such descriptor. `done_o` never pulses otherwise.
- R10: A memory request keeps its address, write flag, size and write data stable until `mem_ready_i`. Only one access is outstanding at a time. Byte reads use `mem_rdata_i[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| base_i | input | 32 | Byte address of the first descriptor |
| busy_o | output | 1 | High from start until the last descriptor finishes |
| done_o | output | 1 | One-cycle completion strobe |
| done_vec_o | output | 32 | Vector field of the finished descriptor, valid with `done_o` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_half_o | output | 1 | 1 halfword access, 0 byte access |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 16 | Write data (byte writes use bits 7:0) |
| mem_ready_i | input | 1 | Access accepted and completed this cycle |
| mem_rdata_i | input | 16 | Read data, valid with `mem_ready_i` |

## Verification
A wrong field pointer during descriptor fetch is the most damaging fault. It shows up at the ports as a wrong total number of reads and as destination bytes at the wrong addresses, or a bad vector on `done_o`. All of this is visible by the time `busy_o` falls, so the bench compares the whole memory image and the read count after every run. Arithmetic or address-stepping faults corrupt the first or second destination unit, so short counts expose them. A broken port handshake changes the address while a request is still waiting and is caught within one stalled cycle.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int ADDR_W = 32;
  localparam int HW_W   = 16;
  localparam int PAIR_W = 3;
  localparam int IDX_W  = 5;
  localparam int PAIR_SLOTS = 1 << PAIR_W;

  typedef enum logic [2:0] {
    FLD_MODE, FLD_COUNT, FLD_SRC, FLD_OPR, FLD_DST, FLD_CHN, FLD_VEC
  } fld_e;

  typedef struct packed {
    logic              imm;
    logic              calc;
    logic              chain;
    logic              vec;
    logic              multi;
    logic [PAIR_W-1:0] npairs;
    logic              half;
  } mode_t;

  typedef struct packed {
    fld_e              fld;
    logic [PAIR_W-1:0] pair;
    logic              hi;
  } slot_t;

  // Pair-list mode masks the single-transfer options.
  function automatic mode_t decode_mode(input logic [HW_W-1:0] raw);
    mode_t m;
    m.multi  = raw[4];
    m.imm    = raw[0] & ~raw[4];
    m.calc   = raw[1] & ~raw[4];
    m.chain  = raw[2] & ~raw[4];
    m.vec    = raw[3] & ~raw[4];
    m.npairs = raw[4] ? raw[7:5] : '0;
    m.half   = raw[8];
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] desc_halfwords(input mode_t m);
    logic [IDX_W-1:0] n;
    if (m.multi) begin
      n = 5'd2 + {m.npairs, 2'b00};
    end else begin
      n = 5'd6;
      if (m.calc)  n = n + 5'd2;
      if (m.chain) n = n + 5'd2;
      if (m.vec)   n = n + 5'd2;
    end
    return n;
  endfunction

  // Which field a given descriptor halfword belongs to.
  function automatic slot_t locate(input mode_t m, input logic [IDX_W-1:0] idx);
    slot_t s;
    logic [IDX_W-1:0] k;
    logic [3:0] pos;
    k      = idx - 5'd2;
    pos    = k[4:1];
    s.fld  = FLD_MODE;
    s.pair = '0;
    s.hi   = k[0];
    if (idx == 5'd0) begin
      s.fld = FLD_MODE;
    end else if (idx == 5'd1) begin
      s.fld = FLD_COUNT;
    end else if (m.multi) begin
      s.pair = k[4:2];
      s.fld  = k[1] ? FLD_DST : FLD_SRC;
    end else if (pos == 4'd0) begin
      s.fld = FLD_SRC;
    end else begin
      pos = pos - 4'd1;
      if (m.calc && pos == 4'd0) begin
        s.fld = FLD_OPR;
      end else begin
        if (m.calc) pos = pos - 4'd1;
        if (pos == 4'd0) begin
          s.fld = FLD_DST;
        end else begin
          pos = pos - 4'd1;
          s.fld = (m.chain && pos == 4'd0) ? FLD_CHN : FLD_VEC;
        end
      end
    end
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] unit_step(input logic half);
    return half ? 32'd2 : 32'd1;
  endfunction

  function automatic logic [HW_W-1:0] unit_trim(input logic [HW_W-1:0] v, input logic half);
    return half ? v : {8'h00, v[7:0]};
  endfunction

  function automatic logic [HW_W-1:0] unit_add(input logic [HW_W-1:0] a,
                                               input logic [HW_W-1:0] b,
                                               input logic half);
    return unit_trim(a + b, half);
  endfunction
endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_desc_pkg::*;
(
  input  logic [HW_W-1:0]  mode_raw_i,
  output mode_t            mode_o,
  output logic [IDX_W-1:0] desc_hw_o
);
  always_comb begin
    mode_o    = decode_mode(mode_raw_i);
    desc_hw_o = desc_halfwords(mode_o);
  end
endmodule

// File: rtl/dma_mem_port.sv
module dma_mem_port
  import dma_desc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = HW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic          cmd_half_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_half_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          pend_q, we_q, half_q, rsp_valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rsp_data_q;
  logic          accept_w;

  assign accept_w = pend_q & mem_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      we_q        <= 1'b0;
      half_q      <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (cmd_valid_i && !pend_q) begin
        pend_q  <= 1'b1;
        we_q    <= cmd_we_i;
        half_q  <= cmd_half_i;
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_wdata_i;
      end else if (accept_w) begin
        pend_q      <= 1'b0;
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= we_q ? '0 : unit_trim(mem_rdata_i, half_q);
      end
    end
  end

  assign mem_req_o   = pend_q;
  assign mem_we_o    = we_q;
  assign mem_half_o  = half_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_half_o) && $stable(mem_wdata_o)));

  assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i |-> !mem_req_o);
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] done_vec_o,
  output logic              cmd_valid_o,
  output logic              cmd_we_o,
  output logic              cmd_half_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [HW_W-1:0]   cmd_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [HW_W-1:0]   rsp_data_i
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SRC, S_OPR, S_WR, S_FIN} state_e;

  state_e            state_q;
  logic [ADDR_W-1:0] base_q, opr_q, chn_q, vec_q, ofs_q, dvec_q;
  logic [ADDR_W-1:0] src_q [PAIR_SLOTS];
  logic [ADDR_W-1:0] dst_q [PAIR_SLOTS];
  logic [IDX_W-1:0]  idx_q;
  logic [HW_W-1:0]   mode_q, count_q, left_q, val_q;
  logic [PAIR_W-1:0] pair_q;
  logic              wait_q, done_q;

  mode_t             md;
  logic [IDX_W-1:0]  desc_hw;
  slot_t             slot_w;
  logic              fetch_last_w, unit_done_w;
  logic [HW_W-1:0]   units_w;
  logic [ADDR_W-1:0] src_addr_w, dst_addr_w, opr_addr_w;

  dma_mode_decode u_dec (
    .mode_raw_i (mode_q),
    .mode_o     (md),
    .desc_hw_o  (desc_hw)
  );

  // Named internal events used by the sequencer and the assertions.
  assign slot_w       = locate(md, idx_q);
  assign fetch_last_w = (idx_q != '0) && (idx_q + 5'd1 == desc_hw);
  assign unit_done_w  = (state_q == S_WR) && rsp_valid_i;
  assign units_w      = md.multi ? {{(HW_W-PAIR_W){1'b0}}, md.npairs} : count_q;
  assign src_addr_w   = md.multi ? src_q[pair_q] : src_q[0] + ofs_q;
  assign dst_addr_w   = md.multi ? dst_q[pair_q] : dst_q[0] + ofs_q;
  assign opr_addr_w   = opr_q + ofs_q;

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_we_o    = 1'b0;
    cmd_half_o  = md.half;
    cmd_addr_o  = '0;
    cmd_wdata_o = val_q;
    case (state_q)
      S_FETCH: begin
        cmd_valid_o = !wait_q;
        cmd_half_o  = 1'b1;
        cmd_addr_o  = base_q + {{(ADDR_W-IDX_W-1){1'b0}}, idx_q, 1'b0};
      end
      S_SRC: begin
        cmd_valid_o = !wait_q && !md.imm;
        cmd_addr_o  = src_addr_w;
      end
      S_OPR: begin
        cmd_valid_o = !wait_q;
        cmd_addr_o  = opr_addr_w;
      end
      S_WR: begin
        cmd_valid_o = !wait_q;
        cmd_we_o    = 1'b1;
        cmd_addr_o  = dst_addr_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      opr_q   <= '0;
      chn_q   <= '0;
      vec_q   <= '0;
      ofs_q   <= '0;
      dvec_q  <= '0;
      idx_q   <= '0;
      mode_q  <= '0;
      count_q <= '0;
      left_q  <= '0;
      val_q   <= '0;
      pair_q  <= '0;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
      for (int i = 0; i < PAIR_SLOTS; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (cmd_valid_o) wait_q <= 1'b1;
      else if (rsp_valid_i) wait_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            base_q  <= base_i;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (rsp_valid_i) begin
            case (slot_w.fld)
              FLD_MODE:  mode_q  <= rsp_data_i;
              FLD_COUNT: count_q <= rsp_data_i;
              FLD_SRC: if (slot_w.hi) src_q[slot_w.pair][31:16] <= rsp_data_i;
                       else           src_q[slot_w.pair][15:0]  <= rsp_data_i;
              FLD_DST: if (slot_w.hi) dst_q[slot_w.pair][31:16] <= rsp_data_i;
                       else           dst_q[slot_w.pair][15:0]  <= rsp_data_i;
              FLD_OPR: if (slot_w.hi) opr_q[31:16] <= rsp_data_i;
                       else           opr_q[15:0]  <= rsp_data_i;
              FLD_CHN: if (slot_w.hi) chn_q[31:16] <= rsp_data_i;
                       else           chn_q[15:0]  <= rsp_data_i;
              default: if (slot_w.hi) vec_q[31:16] <= rsp_data_i;
                       else           vec_q[15:0]  <= rsp_data_i;
            endcase
            if (fetch_last_w) begin
              idx_q   <= '0;
              ofs_q   <= '0;
              pair_q  <= '0;
              left_q  <= units_w;
              state_q <= (units_w == '0) ? S_FIN : S_SRC;
            end else begin
              idx_q <= idx_q + 5'd1;
            end
          end
        end
        S_SRC: begin
          if (md.imm) begin
            val_q   <= unit_trim(src_q[0][15:0], md.half);
            state_q <= md.calc ? S_OPR : S_WR;
          end else if (rsp_valid_i) begin
            val_q   <= rsp_data_i;
            state_q <= md.calc ? S_OPR : S_WR;
          end
        end
        S_OPR: begin
          if (rsp_valid_i) begin
            val_q   <= unit_add(val_q, rsp_data_i, md.half);
            state_q <= S_WR;
          end
        end
        S_WR: begin
          if (unit_done_w) begin
            left_q  <= left_q - 16'd1;
            pair_q  <= pair_q + 3'd1;
            ofs_q   <= ofs_q + unit_step(md.half);
            state_q <= (left_q == 16'd1) ? S_FIN : S_SRC;
          end
        end
        S_FIN: begin
          done_q <= md.vec;
          dvec_q <= vec_q;
          if (md.chain) begin
            base_q  <= chn_q;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign done_vec_o = dvec_q;

  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  assert_pair_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (md.multi && (state_q == S_SRC || state_q == S_WR)) |-> (pair_q < md.npairs));

  assert_fetch_in_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH && idx_q > 5'd1) |-> (idx_q < desc_hw));
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] done_vec_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_half_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [HW_W-1:0]   mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [HW_W-1:0]   mem_rdata_i
);
  logic              cmd_valid, cmd_we, cmd_half, rsp_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [HW_W-1:0]   cmd_wdata, rsp_data;

  dma_xfer_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .base_i      (base_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .done_vec_o  (done_vec_o),
    .cmd_valid_o (cmd_valid),
    .cmd_we_o    (cmd_we),
    .cmd_half_o  (cmd_half),
    .cmd_addr_o  (cmd_addr),
    .cmd_wdata_o (cmd_wdata),
    .rsp_valid_i (rsp_valid),
    .rsp_data_i  (rsp_data)
  );

  dma_mem_port #(.AW(ADDR_W), .DW(HW_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_we_i    (cmd_we),
    .cmd_half_i  (cmd_half),
    .cmd_addr_i  (cmd_addr),
    .cmd_wdata_i (cmd_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_half_o  (mem_half_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i)
  );
endmodule

// File: tb/dma_desc_engine_tb.sv
module dma_desc_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_in = '0;
  logic        busy, done, req, we, half, ready;
  logic [31:0] dvec, maddr;
  logic [15:0] wdata, rdata;

  always #5 clk = ~clk;

  dma_desc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base_in),
    .busy_o(busy), .done_o(done), .done_vec_o(dvec),
    .mem_req_o(req), .mem_we_o(we), .mem_half_o(half), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .mem_ready_i(ready), .mem_rdata_i(rdata)
  );

  logic [7:0] mem  [0:1023];
  logic [7:0] expm [0:1023];
  logic [7:0] lfsr = 8'hA5;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int reads, writes, dones, busy_falls, exp_reads;
  logic [31:0] last_vec;
  logic busy_prev = 1'b0;

  // {mode, count, source field}; operand 0x280, destination 0x300, vector 0xC0DE000i
  localparam logic [63:0] TBL [0:8] = '{
    64'h0000_0005_0000_0200, 64'h0100_0004_0000_0200, 64'h0001_0003_DEAD_12A5,
    64'h0101_0002_DEAD_12A5, 64'h0002_0004_0000_0200, 64'h0102_0003_0000_0200,
    64'h0008_0002_0000_0200, 64'h010B_0002_DEAD_12A5, 64'h0008_0000_0000_0200
  };

  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign ready = lfsr[0] | lfsr[2];
  assign rdata = {mem[maddr[9:0] + 10'd1], mem[maddr[9:0]]};

  always @(negedge clk) begin
    if (req && ready) begin
      if (we) begin
        mem[maddr[9:0]] = wdata[7:0];
        if (half) mem[maddr[9:0] + 10'd1] = wdata[15:8];
        writes++;
      end else reads++;
    end
    if (done) begin dones++; last_vec = dvec; end
    if (busy_prev && !busy) busy_falls++;
    busy_prev = busy;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic put16(input int a, input logic [15:0] v);
    mem[a] = v[7:0]; mem[a+1] = v[15:8];
  endtask
  task automatic put32(input int a, input logic [31:0] v);
    put16(a, v[15:0]); put16(a + 2, v[31:16]);
  endtask

  task automatic init_mem();
    for (int a = 0; a < 1024; a++) mem[a] = 8'(a * 7 + 3);
    for (int a = 'h300; a < 'h340; a++) mem[a] = 8'h5A;
  endtask
  task automatic snap();
    for (int a = 0; a < 1024; a++) expm[a] = mem[a];
    reads = 0; writes = 0; dones = 0; busy_falls = 0; last_vec = '0;
  endtask

  task automatic start_run(input logic [31:0] b);
    @(negedge clk); start = 1'b1; base_in = b;
    @(negedge clk); start = 1'b0; base_in = 32'h0000_03F0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_mem(input string rq, input string what);
    int bad = 0, first = 0;
    for (int a = 0; a < 1024; a++)
      if (mem[a] !== expm[a]) begin if (bad == 0) first = a; bad++; end
    check(bad == 0, rq, $sformatf("%s memory image at %h", what, first),
          {24'h0, mem[first]}, {24'h0, expm[first]});
  endtask

  // Build a single descriptor at 0x100 in field order and predict its effect.
  task automatic build_single(input logic [15:0] md, input logic [15:0] cnt,
                              input logic [31:0] src, input logic [31:0] vecv);
    int p = 'h100, s;
    logic [15:0] v, o;
    bit imm, calc, hw, vc;
    imm = md[0]; calc = md[1]; vc = md[3]; hw = md[8];
    s = hw ? 2 : 1;
    init_mem();
    put16(p, md); p += 2; put16(p, cnt); p += 2; put32(p, src); p += 4;
    if (calc) begin put32(p, 32'h280); p += 4; end
    put32(p, 32'h300); p += 4;
    if (vc) put32(p, vecv);
    snap();
    for (int u = 0; u < int'(cnt); u++) begin
      v = imm ? src[15:0] : {mem['h200 + u*s + 1], mem['h200 + u*s]};
      if (!hw) v[15:8] = 8'h00;
      if (calc) begin
        o = {mem['h280 + u*s + 1], mem['h280 + u*s]};
        if (!hw) o[15:8] = 8'h00;
        v = v + o;
        if (!hw) v[15:8] = 8'h00;
      end
      expm['h300 + u*s] = v[7:0];
      if (hw) expm['h300 + u*s + 1] = v[15:8];
    end
    exp_reads = 6 + (calc ? 2 : 0) + (vc ? 2 : 0) +
                int'(cnt) * ((imm ? 0 : 1) + (calc ? 1 : 0));
  endtask

  task automatic run_pairs(input logic [15:0] md, input int n);
    int p = 'h104, s;
    s = md[8] ? 2 : 1;
    init_mem();
    put16('h100, md); put16('h102, 16'h0009);
    for (int k = 0; k < n; k++) begin
      put32(p, 32'h200 + 32'(k * 16)); put32(p + 4, 32'h300 + 32'(k * 4)); p += 8;
    end
    snap();
    for (int k = 0; k < n; k++)
      for (int b = 0; b < s; b++) expm['h300 + k*4 + b] = mem['h200 + k*16 + b];
    start_run(32'h100);
    wait_idle();
    cmp_mem("R7", $sformatf("pair list n=%0d", n));
    check(reads == 2 + 5 * n, "R7", "pair list read count", 32'(reads), 32'(2 + 5 * n));
    check(dones == 0, "R7", "vector bit ignored in pair list", 32'(dones), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1", "busy after reset", {31'h0, busy}, 0);
    check(!req, "R1", "request after reset", {31'h0, req}, 0);
    check(!done, "R1", "done after reset", {31'h0, done}, 0);

    // Table of single descriptors.
    for (int i = 0; i < 9; i++) begin
      logic [15:0] md, cnt;
      logic [31:0] src;
      string tg;
      md = TBL[i][63:48]; cnt = TBL[i][47:32]; src = TBL[i][31:0];
      tg = md[1] ? "R5" : md[0] ? "R4" : (cnt == 0) ? "R6" : "R3";
      build_single(md, cnt, src, 32'hC0DE_0000 + 32'(i));
      start_run(32'h100);
      wait_idle();
      cmp_mem(tg, $sformatf("entry %0d", i));
      check(reads == exp_reads, "R2", $sformatf("entry %0d read count", i),
            32'(reads), 32'(exp_reads));
      check(dones == (md[3] ? 1 : 0), "R9", $sformatf("entry %0d done pulses", i),
            32'(dones), {31'h0, md[3]});
      if (md[3])
        check(last_vec == 32'hC0DE_0000 + 32'(i), "R9", $sformatf("entry %0d vector", i),
              last_vec, 32'hC0DE_0000 + 32'(i));
      check(!busy && busy_falls == 1, "R1", $sformatf("entry %0d busy ends", i),
            32'(busy_falls), 1);
    end

    // R1: a second start while busy is ignored.
    build_single(16'h0000, 16'd5, 32'h200, 32'h0);
    start_run(32'h100);
    repeat (3) @(negedge clk);
    start_run(32'h180);
    wait_idle();
    cmp_mem("R1", "start while busy");
    check(reads == 11, "R1", "start while busy read count", 32'(reads), 11);

    // R8: follow-on descriptor, both with vectors.
    init_mem();
    put16('h100, 16'h000C); put16('h102, 16'd2); put32('h104, 32'h200);
    put32('h108, 32'h300); put32('h10C, 32'h140); put32('h110, 32'h1111_0000);
    put16('h140, 16'h0108); put16('h142, 16'd1); put32('h144, 32'h210);
    put32('h148, 32'h310); put32('h14C, 32'h55AA_0001);
    snap();
    expm['h300] = mem['h200]; expm['h301] = mem['h201];
    expm['h310] = mem['h210]; expm['h311] = mem['h211];
    start_run(32'h100);
    wait_idle();
    cmp_mem("R8", "chained pair of descriptors");
    check(busy_falls == 1, "R8", "busy held across chain", 32'(busy_falls), 1);
    check(reads == 21, "R8", "chained read count", 32'(reads), 21);
    check(dones == 2, "R9", "one pulse per vector descriptor", 32'(dones), 2);
    check(last_vec == 32'h55AA_0001, "R9", "vector of second descriptor", last_vec, 32'h55AA_0001);

    // R7: pair lists (halfword with ignored bits, seven bytes, empty).
    run_pairs(16'h0179, 3);
    run_pairs(16'h00F0, 7);
    run_pairs(16'h0010, 0);

    summary();
    $finish;
  end
endmodule